// File: doc/BRIEF.md
# Stack Sequencer for Push, Pop, Call and Return

This block owns the stack pointer of a small 16-bit processor and carries out every stack transfer against a single word-wide data memory port. A decoder elsewhere raises `start` for one cycle together with an operation code, an operand (the value to push, or the call target) and the instruction pointer in force. The sequencer then issues exactly one memory access, waits for the memory to accept it, and reports the result through registered outputs. Decoding of other instructions and operand addressing live outside this block.

The stack grows downwards. A push lowers the pointer by one word (two bytes) and writes at the lowered address. A pop reads at the current address and then raises the pointer by one word. A subroutine call is a push of the instruction pointer that also loads a new pointer value from the operand. A plain return and an interrupt return are both pops into the instruction pointer; the interrupt return also pulses requests to set the interrupt-enable flag and to zero the active interrupt id.

The stack pointer and the instruction-pointer output change only at completion, so an aborted or stalled access never leaves a half-updated state visible to the core.

Top module: `call_stack_unit`

## Requirements
- R1: After reset the stack pointer reads 0x0000, `ip_next` reads 0, and `mem_req`, `busy` and `done` are low.
- R2: Operation code 0x24 (push) writes `operand` at address SP-2 (modulo 2^16, so SP 0x0000 gives 0xFFFE) and leaves SP at SP-2.
- R3: Operation code 0x23 (pop) reads at address SP, presents the word on `pop_data` with `pop_valid` high for one cycle, and leaves SP at SP+2.
- R4: Operation code 0x05 (call) writes `cur_ip` at SP-2, leaves SP at SP-2, and presents `operand` on `ip_next` with `ip_load` high for one cycle.
- R5: Operation code 0x25 (return) reads at SP, presents the word on `ip_next` with `ip_load` high for one cycle, and leaves SP at SP+2; it raises neither flag request.
- R6: Operation code 0x0f (interrupt return) behaves as R5 and additionally pulses `irq_en_set` and `irq_id_clr` in the same cycle as `done`; no other operation raises them.
- R7: Once `mem_req` is high it stays high, with `mem_addr`, `mem_we` and `mem_wdata` unchanged, until a cycle in which `mem_ready` is high; an operation spends latency+1 cycles with `mem_req` high.
- R8: `done` is high for exactly one cycle, the cycle after the accepted memory access; `busy` is high from the cycle after `start` up to that access.
- R9: A `start` that arrives while `busy` is high is ignored: no second memory access takes place and no request follows the finished one.
- R10: `sp_out` and `ip_next` hold their values in every cycle in which `done` is low.
- R11: A `start` with any operation code other than 0x05, 0x0f, 0x23, 0x24 or 0x25 is ignored: no memory request, no `done`, and SP unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin an operation |
| op_code | input | 8 | Operation selector sampled with `start` |
| operand | input | DW (16) | Value to push, or call target |
| cur_ip | input | AW (16) | Instruction pointer saved by a call |
| mem_req | output | 1 | Memory access request, held until ready |
| mem_we | output | 1 | High for a write access |
| mem_addr | output | AW (16) | Byte address of the stack word |
| mem_wdata | output | DW (16) | Word written on a push or call |
| mem_rdata | input | DW (16) | Word returned by the memory |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle completion pulse |
| ip_load | output | 1 | `ip_next` must be loaded into the instruction pointer |
| ip_next | output | AW (16) | New instruction pointer value |
| pop_valid | output | 1 | `pop_data` carries a freshly popped word |
| pop_data | output | DW (16) | Word read by a pop |
| irq_en_set | output | 1 | Request to set the interrupt-enable flag |
| irq_id_clr | output | 1 | Request to zero the active interrupt id |
| sp_out | output | AW (16) | Current stack pointer |

## Verification
The bench drives the first push from a reset pointer so that the address must wrap to 0xFFFE; a design that decremented after writing, or incremented the wrong way, would write at 0x0000 or 0x0002. It stalls the memory for several cycles and watches the pointer and instruction-pointer outputs, which a design committing at request time rather than at completion would move early, and it counts request cycles to catch a request dropped before ready. A second start injected mid-stall would produce a second access in a design that rearms while busy, and an interrupt return is compared against a plain return so that flag pulses leaking onto the wrong operation show up.

// File: rtl/call_stack_pkg.sv
package call_stack_pkg;

  localparam int OPW = 8;

  localparam logic [OPW-1:0] OPC_CALL = 8'h05;
  localparam logic [OPW-1:0] OPC_IRET = 8'h0f;
  localparam logic [OPW-1:0] OPC_POP  = 8'h23;
  localparam logic [OPW-1:0] OPC_PUSH = 8'h24;
  localparam logic [OPW-1:0] OPC_RET  = 8'h25;

  // Decoded character of one stack operation
  typedef struct packed {
    logic valid;    // a stack operation at all
    logic writes;   // pre-decrement and write (push, call)
    logic use_ip;   // write data is the current instruction pointer
    logic to_ip;    // result goes to the instruction pointer
    logic to_data;  // result goes to pop_data
    logic irq_ret;  // interrupt-return flag side effects
  } op_kind_t;

  typedef enum logic [0:0] {ST_IDLE, ST_XFER} seq_state_t;

endpackage

// File: rtl/csu_decode.sv
module csu_decode
  import call_stack_pkg::*;
(
  input  logic [OPW-1:0] op_code,
  output op_kind_t       kind
);

  always_comb begin
    kind = '0;
    unique case (op_code)
      OPC_PUSH: begin kind.valid = 1'b1; kind.writes = 1'b1; end
      OPC_CALL: begin kind.valid = 1'b1; kind.writes = 1'b1; kind.use_ip = 1'b1; kind.to_ip = 1'b1; end
      OPC_POP:  begin kind.valid = 1'b1; kind.to_data = 1'b1; end
      OPC_RET:  begin kind.valid = 1'b1; kind.to_ip = 1'b1; end
      OPC_IRET: begin kind.valid = 1'b1; kind.to_ip = 1'b1; kind.irq_ret = 1'b1; end
      default:  kind = '0;
    endcase
  end

endmodule

// File: rtl/csu_sp.sv
module csu_sp #(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int SP_INIT = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          commit,
  input  logic          grow,
  output logic [AW-1:0] sp_q,
  output logic [AW-1:0] sp_dn
);

  localparam int STEP = DW / 8;
  localparam logic [AW-1:0] STEP_V = AW'(STEP);
  localparam logic [AW-1:0] INIT_V = AW'(SP_INIT);

  assign sp_dn = sp_q - STEP_V;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= INIT_V;
    end else if (commit) begin
      sp_q <= grow ? sp_dn : (sp_q + STEP_V);
    end
  end

  // A committed operation moves the pointer by exactly one word
  assert_sp_step_R10: assert property (@(posedge clk) disable iff (rst)
    commit |=> ((sp_q == $past(sp_q) - STEP_V) || (sp_q == $past(sp_q) + STEP_V)));

endmodule

// File: rtl/csu_seq.sv
module csu_seq
  import call_stack_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  op_kind_t      kind,
  input  logic [DW-1:0] operand,
  input  logic [AW-1:0] cur_ip,
  input  logic [AW-1:0] sp_q,
  input  logic [AW-1:0] sp_dn,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          sp_commit,
  output logic          sp_grow,
  output logic          busy,
  output logic          done,
  output logic          ip_load,
  output logic [AW-1:0] ip_next,
  output logic          pop_valid,
  output logic [DW-1:0] pop_data,
  output logic          irq_en_set,
  output logic          irq_id_clr
);

  seq_state_t    state;
  op_kind_t      held;
  logic [AW-1:0] target;

  assign busy      = (state == ST_XFER);
  assign sp_commit = busy && mem_ready;
  assign sp_grow   = held.writes;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      held       <= '0;
      target     <= '0;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      done       <= 1'b0;
      ip_load    <= 1'b0;
      ip_next    <= '0;
      pop_valid  <= 1'b0;
      pop_data   <= '0;
      irq_en_set <= 1'b0;
      irq_id_clr <= 1'b0;
    end else begin
      done       <= 1'b0;
      ip_load    <= 1'b0;
      pop_valid  <= 1'b0;
      irq_en_set <= 1'b0;
      irq_id_clr <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start && kind.valid) begin
            state     <= ST_XFER;
            held      <= kind;
            target    <= AW'(operand);
            mem_req   <= 1'b1;
            mem_we    <= kind.writes;
            mem_addr  <= kind.writes ? sp_dn : sp_q;
            mem_wdata <= kind.use_ip ? DW'(cur_ip) : operand;
          end
        end
        ST_XFER: begin
          if (mem_ready) begin
            state   <= ST_IDLE;
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            done    <= 1'b1;
            if (held.to_ip) begin
              ip_load <= 1'b1;
              ip_next <= held.writes ? target : AW'(mem_rdata);
            end
            if (held.to_data) begin
              pop_valid <= 1'b1;
              pop_data  <= mem_rdata;
            end
            if (held.irq_ret) begin
              irq_en_set <= 1'b1;
              irq_id_clr <= 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_follows_access_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ready) |=> done);

  assert_no_rearm_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ready) |=> !mem_req);

  assert_flags_with_ip_R6: assert property (@(posedge clk) disable iff (rst)
    irq_en_set |-> (done && ip_load && irq_id_clr));

endmodule

// File: rtl/call_stack_unit.sv
module call_stack_unit
  import call_stack_pkg::*;
#(
  parameter int AW      = 16,
  parameter int DW      = 16,
  parameter int SP_INIT = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [7:0]    op_code,
  input  logic [DW-1:0] operand,
  input  logic [AW-1:0] cur_ip,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          mem_ready,
  output logic          busy,
  output logic          done,
  output logic          ip_load,
  output logic [AW-1:0] ip_next,
  output logic          pop_valid,
  output logic [DW-1:0] pop_data,
  output logic          irq_en_set,
  output logic          irq_id_clr,
  output logic [AW-1:0] sp_out
);

  generate
    if (AW > DW) begin : g_width_check
      $error("call_stack_unit: address wider than a stack word cannot be saved");
    end
  endgenerate

  op_kind_t      kind;
  logic          sp_commit;
  logic          sp_grow;
  logic [AW-1:0] sp_q;
  logic [AW-1:0] sp_dn;

  csu_decode u_decode (
    .op_code (op_code),
    .kind    (kind)
  );

  csu_sp #(.AW(AW), .DW(DW), .SP_INIT(SP_INIT)) u_sp (
    .clk    (clk),
    .rst    (rst),
    .commit (sp_commit),
    .grow   (sp_grow),
    .sp_q   (sp_q),
    .sp_dn  (sp_dn)
  );

  csu_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .kind       (kind),
    .operand    (operand),
    .cur_ip     (cur_ip),
    .sp_q       (sp_q),
    .sp_dn      (sp_dn),
    .mem_rdata  (mem_rdata),
    .mem_ready  (mem_ready),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .sp_commit  (sp_commit),
    .sp_grow    (sp_grow),
    .busy       (busy),
    .done       (done),
    .ip_load    (ip_load),
    .ip_next    (ip_next),
    .pop_valid  (pop_valid),
    .pop_data   (pop_data),
    .irq_en_set (irq_en_set),
    .irq_id_clr (irq_id_clr)
  );

  assign sp_out = sp_q;

  assert_sp_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(sp_out));

  assert_ip_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(ip_next));

  assert_bad_code_R11: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && !kind.valid) |=> !mem_req);

endmodule

// File: tb/call_stack_unit_test.sv
module call_stack_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  op_i = 8'h00;
  logic [15:0] opnd_i = 16'h0;
  logic [15:0] ip_i = 16'h0;
  logic        mem_req, mem_we, mem_ready;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic        busy, done, ip_load, pop_valid, irq_en_set, irq_id_clr;
  logic [15:0] ip_next, pop_data, sp_out;

  always #5 clk = ~clk;

  call_stack_unit uut (
    .clk(clk), .rst(rst), .start(start), .op_code(op_i), .operand(opnd_i), .cur_ip(ip_i),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .busy(busy), .done(done),
    .ip_load(ip_load), .ip_next(ip_next), .pop_valid(pop_valid), .pop_data(pop_data),
    .irq_en_set(irq_en_set), .irq_id_clr(irq_id_clr), .sp_out(sp_out)
  );

  // Memory model with programmable stall
  logic [15:0] mem [0:63];
  int lat = 0;
  int wait_cnt, req_cyc, hs_cnt;
  logic [15:0] hs_addr, hs_wdata;
  logic        hs_we;

  assign mem_ready = mem_req && (wait_cnt >= lat);
  assign mem_rdata = mem[mem_addr[6:1]];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) mem[i] <= 16'hC000 | 16'(i);
      wait_cnt <= 0; req_cyc <= 0; hs_cnt <= 0;
      hs_addr <= '0; hs_wdata <= '0; hs_we <= 1'b0;
    end else begin
      if (mem_req && !mem_ready) wait_cnt <= wait_cnt + 1; else wait_cnt <= 0;
      if (mem_req) req_cyc <= req_cyc + 1;
      if (mem_req && mem_ready) begin
        hs_cnt <= hs_cnt + 1; hs_addr <= mem_addr; hs_we <= mem_we; hs_wdata <= mem_wdata;
        if (mem_we) mem[mem_addr[6:1]] <= mem_wdata;
      end
    end
  end

  int vectors = 0, fails = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // Results captured by run_op
  int r_hs, r_req;
  bit r_quiet, r_busy, r_done_after, r_timeout;
  logic r_ip_load, r_pop_valid, r_ie, r_iid;
  logic [15:0] r_ip, r_pop, r_sp;

  task automatic run_op(input logic [7:0] op, input logic [15:0] opnd, input logic [15:0] ip,
                        input int l, input bit inject);
    int base_hs, base_rq, n;
    logic [15:0] sp0, ip0;
    @(negedge clk);
    lat = l; base_hs = hs_cnt; base_rq = req_cyc; sp0 = sp_out; ip0 = ip_next;
    op_i = op; opnd_i = opnd; ip_i = ip; start = 1'b1;
    @(negedge clk);
    start = 1'b0; r_busy = busy; r_quiet = 1'b1; n = 0;
    while (!done && n < 60) begin
      if (sp_out != sp0 || ip_next != ip0) r_quiet = 1'b0;
      start = inject && (n == 1);
      if (inject && n == 1) op_i = 8'h24;
      @(negedge clk);
      n++;
    end
    start = 1'b0; op_i = op;
    r_timeout = (n >= 60);
    r_hs = hs_cnt - base_hs; r_req = req_cyc - base_rq;
    r_ip_load = ip_load; r_ip = ip_next; r_pop_valid = pop_valid; r_pop = pop_data;
    r_ie = irq_en_set; r_iid = irq_id_clr; r_sp = sp_out;
    @(negedge clk);
    r_done_after = done;
    chk(!r_timeout, "R8", "done reached", 32'(n), 32'd0);
  endtask

  task automatic t_reset;
    chk(sp_out == 16'h0000, "R1", "sp after reset", sp_out, 16'h0000);
    chk(ip_next == 16'h0000, "R1", "ip after reset", ip_next, 16'h0000);
    chk(!mem_req && !busy && !done, "R1", "req/busy/done after reset",
        {mem_req, busy, done}, 3'b000);
  endtask

  task automatic t_push_wrap;
    run_op(8'h24, 16'h1234, 16'h0, 0, 1'b0);
    chk(hs_addr == 16'hFFFE && hs_we, "R2", "push address/we", {hs_we, hs_addr}, {1'b1, 16'hFFFE});
    chk(hs_wdata == 16'h1234, "R2", "push data", hs_wdata, 16'h1234);
    chk(r_sp == 16'hFFFE, "R2", "sp after push", r_sp, 16'hFFFE);
    chk(r_busy, "R8", "busy after start", r_busy, 1);
    chk(!r_done_after, "R8", "done width", r_done_after, 0);
    chk(!r_ip_load && !r_pop_valid && !r_ie, "R6", "push side pulses", {r_ip_load, r_pop_valid, r_ie}, 0);
  endtask

  task automatic t_push_stall;
    run_op(8'h24, 16'hBEEF, 16'h0, 3, 1'b0);
    chk(hs_addr == 16'hFFFC, "R2", "second push address", hs_addr, 16'hFFFC);
    chk(r_req == 4, "R7", "request cycles with latency 3", r_req, 4);
    chk(r_quiet, "R10", "sp/ip quiet during stall", r_quiet, 1);
    chk(r_sp == 16'hFFFC, "R2", "sp after second push", r_sp, 16'hFFFC);
  endtask

  task automatic t_pop;
    run_op(8'h23, 16'h0, 16'h0, 2, 1'b0);
    chk(hs_addr == 16'hFFFC && !hs_we, "R3", "pop address/read", {hs_we, hs_addr}, {1'b0, 16'hFFFC});
    chk(r_pop_valid && r_pop == 16'hBEEF, "R3", "popped word", {r_pop_valid, r_pop}, {1'b1, 16'hBEEF});
    chk(r_sp == 16'hFFFE, "R3", "sp after pop", r_sp, 16'hFFFE);
    chk(!r_ip_load, "R3", "pop leaves ip", r_ip_load, 0);
  endtask

  task automatic t_call_ret;
    run_op(8'h05, 16'h0400, 16'h0123, 1, 1'b0);
    chk(hs_addr == 16'hFFFC && hs_we && hs_wdata == 16'h0123, "R4", "call saves ip",
        {hs_we, hs_addr, hs_wdata}, {1'b1, 16'hFFFC, 16'h0123});
    chk(r_ip_load && r_ip == 16'h0400, "R4", "call target", {r_ip_load, r_ip}, {1'b1, 16'h0400});
    chk(r_sp == 16'hFFFC, "R4", "sp after call", r_sp, 16'hFFFC);
    run_op(8'h25, 16'h0, 16'h0, 2, 1'b0);
    chk(r_ip_load && r_ip == 16'h0123, "R5", "return ip", {r_ip_load, r_ip}, {1'b1, 16'h0123});
    chk(r_sp == 16'hFFFE && hs_addr == 16'hFFFC, "R5", "sp/address on return",
        {r_sp, hs_addr}, {16'hFFFE, 16'hFFFC});
    chk(!r_ie && !r_iid, "R5", "no flag pulses on return", {r_ie, r_iid}, 0);
    chk(r_quiet, "R10", "ip quiet during return", r_quiet, 1);
  endtask

  task automatic t_iret;
    run_op(8'h24, 16'h0777, 16'h0, 0, 1'b0);
    run_op(8'h0f, 16'h0, 16'h0, 1, 1'b0);
    chk(r_ip_load && r_ip == 16'h0777, "R6", "interrupt return ip", {r_ip_load, r_ip}, {1'b1, 16'h0777});
    chk(r_ie && r_iid, "R6", "flag pulses", {r_ie, r_iid}, 2'b11);
    chk(r_sp == 16'hFFFE, "R6", "sp after interrupt return", r_sp, 16'hFFFE);
  endtask

  task automatic t_busy_ignore;
    int extra;
    run_op(8'h23, 16'h0, 16'h0, 4, 1'b1);
    chk(r_hs == 1, "R9", "accesses for one op with extra start", r_hs, 1);
    chk(r_sp == 16'h0000, "R9", "sp after pop with extra start", r_sp, 16'h0000);
    extra = 0;
    repeat (5) begin @(negedge clk); if (mem_req) extra++; end
    chk(extra == 0, "R9", "no request after finish", extra, 0);
  endtask

  task automatic t_bad_code;
    int reqs, dones;
    logic [15:0] sp0;
    @(negedge clk);
    sp0 = sp_out; op_i = 8'h06; start = 1'b1;
    @(negedge clk); start = 1'b0;
    reqs = 0; dones = 0;
    repeat (4) begin if (mem_req) reqs++; if (done) dones++; @(negedge clk); end
    chk(reqs == 0 && dones == 0, "R11", "unsupported code activity", {reqs[15:0], dones[15:0]}, 0);
    chk(sp_out == sp0, "R11", "sp unchanged", sp_out, sp0);
  endtask

  task automatic t_pop_low;
    run_op(8'h23, 16'h0, 16'h0, 0, 1'b0);
    chk(hs_addr == 16'h0000 && r_pop == 16'hC000, "R3", "pop at address zero",
        {hs_addr, r_pop}, {16'h0000, 16'hC000});
    chk(r_sp == 16'h0002, "R3", "sp after low pop", r_sp, 16'h0002);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog expired: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_push_wrap();
    t_push_stall();
    t_pop();
    t_call_ret();
    t_iret();
    t_busy_ignore();
    t_bad_code();
    t_pop_low();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule